// File: doc/BRIEF.md
# Predicated element step sequencer

This block produces the pair of element positions for a vector loop whose source and destination both obey one shared predicate mask. Each side has its own zeroing control. A side with zeroing off is a skipping side: it jumps to the next position whose mask bit is set. A side with zeroing on is a zeroing side: it moves through every position in turn, and it marks each position whose mask bit is clear as an element to be treated as zero. The two positions advance together, one pair per accepted cycle. When the zeroing controls differ, the two positions drift apart.

A pulse on `start` captures the loop length, the mask and the zeroing controls, and the block presents the first pair on the next cycle. Each cycle in which `ready` is high moves the block to the next pair. A low `ready` freezes the pair. The loop finishes when either side runs out of eligible positions below the loop length. At that point `done` rises and stays high until the next `start`. Some instruction forms carry only one zeroing bit. For those, a joint-mode input makes that single bit govern both sides.

Top module: `pred_step_seq`

## Requirements
- R1: After reset, `valid` and `done` are both 0.
- R2: On a skipping side (effective zeroing 0), the emitted positions are only positions whose mask bit (bit i is position i) is 1, and they are in strictly increasing order. Its zeroed flag is always 0.
- R3: On a zeroing side (effective zeroing 1), the emitted positions are 0, 1, 2, … in turn. Its zeroed flag equals the inverse of the mask bit at the emitted position.
- R4: With loop length 4 and mask 0b1101, a skipping source with a zeroing destination emits (0,0), (2,1), (3,2) as (source, destination). Swapping the two controls emits (0,0), (1,2), (2,3). In both cases the loop then ends.
- R5: When the effective controls are equal, the source and destination positions are equal at every emitted pair. With length 4 and mask 0b1101, both sides skipping gives (0,0), (2,2), (3,3). Both sides zeroing gives (0,0), (1,1), (2,2), (3,3).
- R6: When `joint_en` is 1, `joint_zero` sets both effective controls, and `src_zero` and `dst_zero` are ignored.
- R7: When either side has no eligible position left below the loop length, the block drops `valid` and raises `done` in the cycle after the last pair is accepted. `done` stays high until the next `start`.
- R8: A loop length of 0, or a skipping side whose mask has no set bit below the loop length, gives `done` one cycle after `start` and emits no pair.
- R9: While `ready` is 0, the pair and the zeroed flags hold steady. While `ready` is 1, one new pair appears each cycle.
- R10: `start` restarts from position 0 with newly captured inputs, including in the middle of a running loop. The first pair appears in the cycle after `start`.
- R11: Mask bits at positions at or above the loop length have no effect on the emitted pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and restart the loop from position 0 |
| vl | input | $clog2(MAXVL+1) | Loop length, 0 to MAXVL |
| mask | input | MAXVL | Shared predicate; bit i governs position i |
| src_zero | input | 1 | Source zeroing control (1 = step through every position) |
| dst_zero | input | 1 | Destination zeroing control |
| joint_en | input | 1 | Use `joint_zero` for both sides |
| joint_zero | input | 1 | Single zeroing control for joint mode |
| ready | input | 1 | Consumer accepts the current pair |
| valid | output | 1 | A pair is presented |
| src_idx | output | $clog2(MAXVL) | Source position |
| dst_idx | output | $clog2(MAXVL) | Destination position |
| src_zeroed | output | 1 | Source element is to be treated as zero |
| dst_zeroed | output | 1 | Destination element is to be treated as zero |
| done | output | 1 | Loop finished; held until next start |

## Verification
The bench drives the divergent cases in both directions with the reference mask. A design that shared one position counter, or that swapped the meaning of the zeroing control, would put out equal pairs or pairs in mirror image. Joint mode is run with the per-side controls set against the joint bit, so a design that ignored the override would diverge where it should not. The empty cases are also driven: zero length, and a mask that is set only above the length. A block that failed to bound its search would emit a pair from the stray bits or never finish. Stalls and a mid-loop restart are checked as well. A design that advanced regardless of `ready`, or that kept its old position across `start`, would show the wrong pair.

// File: rtl/pred_step_seq.sv
module pred_step_seq #(
  parameter int MAXVL = 64,
  localparam int SW = $clog2(MAXVL),
  localparam int VW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VW-1:0]    vl,
  input  logic [MAXVL-1:0] mask,
  input  logic             src_zero,
  input  logic             dst_zero,
  input  logic             joint_en,
  input  logic             joint_zero,
  input  logic             ready,
  output logic             valid,
  output logic [SW-1:0]    src_idx,
  output logic [SW-1:0]    dst_idx,
  output logic             src_zeroed,
  output logic             dst_zeroed,
  output logic             done
);

  logic [MAXVL-1:0] mask_q;
  logic [VW-1:0]    vl_q;
  logic             sz_q, dz_q;
  logic [SW-1:0]    src_q, dst_q;
  logic             valid_q, done_q;

  function automatic logic [SW:0] seek(input logic [SW:0] from,
                                       input logic [MAXVL-1:0] m,
                                       input logic [VW-1:0] lim,
                                       input logic z);
    logic [SW:0] r;
    r = '0;
    for (int i = MAXVL - 1; i >= 0; i--)
      if (i >= int'(from) && i < int'(lim) && (z || m[i]))
        r = {1'b1, SW'(i)};
    return r;
  endfunction

  wire sz_in = joint_en ? joint_zero : src_zero;
  wire dz_in = joint_en ? joint_zero : dst_zero;

  wire [MAXVL-1:0] m_use  = start ? mask  : mask_q;
  wire [VW-1:0]    vl_use = start ? vl    : vl_q;
  wire             sz_use = start ? sz_in : sz_q;
  wire             dz_use = start ? dz_in : dz_q;

  wire [SW:0] src_from = start ? '0 : {1'b0, src_q} + 1'b1;
  wire [SW:0] dst_from = start ? '0 : {1'b0, dst_q} + 1'b1;

  wire [SW:0] src_nx = seek(src_from, m_use, vl_use, sz_use);
  wire [SW:0] dst_nx = seek(dst_from, m_use, vl_use, dz_use);
  wire        both   = src_nx[SW] & dst_nx[SW];
  wire        adv    = start | (valid_q & ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      vl_q    <= '0;
      sz_q    <= 1'b0;
      dz_q    <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (adv) begin
      if (start) begin
        mask_q <= mask;
        vl_q   <= vl;
        sz_q   <= sz_in;
        dz_q   <= dz_in;
      end
      valid_q <= both;
      done_q  <= ~both;
      if (both) begin
        src_q <= src_nx[SW-1:0];
        dst_q <= dst_nx[SW-1:0];
      end
    end
  end

  assign valid      = valid_q;
  assign done       = done_q;
  assign src_idx    = src_q;
  assign dst_idx    = dst_q;
  assign src_zeroed = valid_q & sz_q & ~mask_q[src_q];
  assign dst_zeroed = valid_q & dz_q & ~mask_q[dst_q];

  // R1 R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && done));

  // R5
  lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sz_q == dz_q) |-> src_idx == dst_idx);

  // R2
  skip_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !sz_q) |-> (mask_q[src_idx] && !src_zeroed));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !start) |=> (valid && $stable(src_idx) && $stable(dst_idx)));

  // R2 R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !start) |=> (!valid || (src_idx > $past(src_idx) && dst_idx > $past(dst_idx))));

  // R11
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (int'(src_idx) < int'(vl_q) && int'(dst_idx) < int'(vl_q)));

endmodule

// File: tb/tb_pred_step_seq.sv
module tb_pred_step_seq;
  localparam int MAXVL = 64;
  localparam int SW = $clog2(MAXVL);
  localparam int VW = $clog2(MAXVL + 1);
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, start = 0, src_zero = 0, dst_zero = 0;
  logic joint_en = 0, joint_zero = 0, ready = 0;
  logic [VW-1:0] vl = '0;
  logic [MAXVL-1:0] mask = '0;
  logic valid, src_zeroed, dst_zeroed, done;
  logic [SW-1:0] src_idx, dst_idx;

  int checks = 0, errors = 0;
  bit finished = 0;

  pred_step_seq #(.MAXVL(MAXVL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .mask(mask),
    .src_zero(src_zero), .dst_zero(dst_zero), .joint_en(joint_en),
    .joint_zero(joint_zero), .ready(ready), .valid(valid),
    .src_idx(src_idx), .dst_idx(dst_idx), .src_zeroed(src_zeroed),
    .dst_zeroed(dst_zeroed), .done(done));

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic kick(input int l, input logic [MAXVL-1:0] m, input bit s,
                      input bit d, input bit je, input bit jz);
    @(negedge clk);
    vl = VW'(l); mask = m; src_zero = s; dst_zero = d;
    joint_en = je; joint_zero = jz; start = 1; ready = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_seq(input string req, input int l, input logic [MAXVL-1:0] m,
                         input bit s, input bit d, input bit je, input bit jz,
                         input int n, input int es[8], input int ed[8]);
    bit se, de;
    se = je ? jz : s;
    de = je ? jz : d;
    kick(l, m, s, d, je, jz);
    for (int k = 0; k < n; k++) begin
      chk(valid === 1'b1, req, "valid", int'(valid), 1);
      chk(int'(src_idx) == es[k], req, "src_idx", int'(src_idx), es[k]);
      chk(int'(dst_idx) == ed[k], req, "dst_idx", int'(dst_idx), ed[k]);
      chk(src_zeroed === (se & ~m[es[k]]), req, "src_zeroed", int'(src_zeroed), int'(se & ~m[es[k]]));
      chk(dst_zeroed === (de & ~m[ed[k]]), req, "dst_zeroed", int'(dst_zeroed), int'(de & ~m[ed[k]]));
      @(negedge clk);
    end
    chk(done === 1'b1 && valid === 1'b0, req, "done at end", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b1, req, "done held (R7)", int'(done), 1);
  endtask

  task automatic t_reset;
    chk(valid === 1'b0, "R1", "valid", int'(valid), 0);
    chk(done === 1'b0, "R1", "done", int'(done), 0);
  endtask

  task automatic t_empty;
    kick(0, 64'hF, 0, 0, 0, 0);
    chk(done === 1'b1 && valid === 1'b0, "R8", "vl0 done", int'(done), 1);
    kick(2, 64'hFC, 0, 1, 0, 0);
    chk(done === 1'b1 && valid === 1'b0, "R8 R11", "high bits only", int'(valid), 0);
    kick(3, 64'hFFF8, 1, 1, 0, 0);
    chk(valid === 1'b1 && src_idx == 0 && src_zeroed === 1'b1, "R11", "zeroing ignores high bits",
        int'(src_zeroed), 1);
  endtask

  task automatic t_stall;
    kick(4, 64'b1101, 0, 1, 0, 0);
    ready = 1;
    @(negedge clk);
    ready = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(valid === 1'b1 && src_idx == 2 && dst_idx == 1, "R9", "held src", int'(src_idx), 2);
      chk(dst_zeroed === 1'b1, "R9", "held dst_zeroed", int'(dst_zeroed), 1);
    end
    ready = 1;
    @(negedge clk);
    chk(src_idx == 3 && dst_idx == 2, "R9", "resume dst", int'(dst_idx), 2);
  endtask

  task automatic t_restart;
    kick(4, 64'b1101, 1, 1, 0, 0);
    @(negedge clk);
    chk(src_idx == 1, "R10", "pre-restart", int'(src_idx), 1);
    start = 1; vl = VW'(3); mask = 64'b110; src_zero = 0; dst_zero = 0;
    @(negedge clk);
    start = 0;
    chk(valid === 1'b1 && src_idx == 1 && dst_idx == 1, "R10", "restart first", int'(src_idx), 1);
    @(negedge clk);
    chk(src_idx == 2 && dst_idx == 2, "R10", "restart second", int'(dst_idx), 2);
    @(negedge clk);
    chk(done === 1'b1, "R10 R7", "restart done", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_seq("R2 R5", 4, 64'b1101, 0, 0, 0, 0, 3, '{0,2,3,0,0,0,0,0}, '{0,2,3,0,0,0,0,0});
    run_seq("R3 R5", 4, 64'b1101, 1, 1, 0, 0, 4, '{0,1,2,3,0,0,0,0}, '{0,1,2,3,0,0,0,0});
    run_seq("R4", 4, 64'b1101, 0, 1, 0, 0, 3, '{0,2,3,0,0,0,0,0}, '{0,1,2,0,0,0,0,0});
    run_seq("R4", 4, 64'b1101, 1, 0, 0, 0, 3, '{0,1,2,0,0,0,0,0}, '{0,2,3,0,0,0,0,0});
    run_seq("R6", 4, 64'b1101, 1, 0, 1, 0, 3, '{0,2,3,0,0,0,0,0}, '{0,2,3,0,0,0,0,0});
    run_seq("R6", 4, 64'b1101, 0, 1, 1, 1, 4, '{0,1,2,3,0,0,0,0}, '{0,1,2,3,0,0,0,0});
    run_seq("R2 R7", 8, 64'b10100100, 0, 1, 0, 0, 3, '{2,5,7,0,0,0,0,0}, '{0,1,2,0,0,0,0,0});
    run_seq("R11", 3, 64'hF0_0000_0101, 0, 0, 0, 0, 1, '{0,0,0,0,0,0,0,0}, '{0,0,0,0,0,0,0,0});
    t_empty();
    t_stall();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule